// File: doc/BRIEF.md
# Multi-Port Pin Function Controller

This block holds the configuration state for every pin across a parameterised number of 32-pin ports and turns it into per-pin control outputs. Each port owns a bank of five 32-bit configuration registers (interrupt, mask, pattern-high, pattern-low, pull-disable), one bit per pin. Software never performs read-modify-write. Each register has a set alias and a clear alias, and a write to either alias changes only the bits where the write data is 1.

From its interrupt, mask and pattern bits, each pin decodes a mode: peripheral function 0 to 3, GPIO input, GPIO output, or interrupt input. Pull-up and pull-down enables come from the pull-disable bit, masked by fixed per-port capability constants. A flag offset returns the pad levels after a two-flop synchronizer. Reads on the 32-bit bus return their data one clock after the request.

Top module: `pinfunc_ctrl`

## Requirements
- R1: The port is `bus_addr_i[ADDR_W-1:8]` and the offset is `bus_addr_i[7:0]`. The base offsets are interrupt 0x10, mask 0x20, pattern-high 0x30, pattern-low 0x40, flag 0x50 and pull-disable 0x70. A read at a base offset returns the register in `bus_rdata_o` on the clock after the request. Pin n is bit n%32 of port n/32.
- R2: On reset, the interrupt, mask and pull-disable registers clear and both pattern registers go to all ones. Every pin therefore starts in function 3 with pulls enabled.
- R3: A write to base+0x4 sets the register bits where the write data is 1. Bits where the data is 0 keep their value.
- R4: A write to base+0x8 clears the register bits where the write data is 1. Bits where the data is 0 keep their value.
- R5: `pin_mode_o[3n+2:3n]` holds the mode of pin n. With interrupt=0 and mask=0, the mode is {pattern-high, pattern-low}, which gives codes 0 to 3.
- R6: With interrupt=0 and mask=1, the mode is 4 (GPIO input) when pattern-high=1 and 5 (GPIO output) when pattern-high=0. In mode 5, `pad_oe_o` is 1 and `pad_out_o` equals pattern-low. In every other mode, both are 0.
- R7: With interrupt=1, the mode is 6 and the pad is not driven.
- R8: `pull_up_o[n]` = !pull-disable & PULLUP_CAP[n]. `pull_dn_o[n]` = !pull-disable & PULLDN_CAP[n].
- R9: A read of the flag offset returns the port's `pad_in_i` bits after two register stages.
- R10: Reads of set or clear aliases and of unmapped offsets return 0. Writes to unmapped offsets and to the flag offset change nothing.
- R11: An access whose port field is NUM_PORTS or higher reads 0 and leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_en_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| pad_in_i | input | NUM_PORTS*32 | Raw pad levels |
| pin_mode_o | output | NUM_PORTS*96 | 3-bit mode per pin |
| pad_out_o | output | NUM_PORTS*32 | GPIO output value |
| pad_oe_o | output | NUM_PORTS*32 | GPIO output enable |
| pull_up_o | output | NUM_PORTS*32 | Pull-up enable |
| pull_dn_o | output | NUM_PORTS*32 | Pull-down enable |

## Verification
The mode decoder is driven through every combination of the four control bits on pins in different ports: pattern-bit changes separate functions 0 to 3, the mask separates GPIO from function, and the interrupt bit overrides both. Set and clear writes are mixed with readbacks, so the bench can tell whether zero bits of the write data are preserved. Pull outputs are checked on pins where only one of the two capabilities exists, which distinguishes the up mask from the down mask. Writes to out-of-range ports and unmapped offsets are followed by pin-output checks and readbacks, to show that nothing moved.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int PORT_PINS = 32;
  localparam int NUM_CFG   = 5;  // int, msk, pat1, pat0, pdis
  localparam int CFG_INT   = 0;
  localparam int CFG_MSK   = 1;
  localparam int CFG_PAT1  = 2;
  localparam int CFG_PAT0  = 3;
  localparam int CFG_PDIS  = 4;
  localparam logic [7:0] OFS_FLAG = 8'h50;
  localparam logic [7:0] OFS_SET  = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;

  typedef enum logic [2:0] {
    PM_FN0 = 3'd0, PM_FN1 = 3'd1, PM_FN2 = 3'd2, PM_FN3 = 3'd3,
    PM_GPI = 3'd4, PM_GPO = 3'd5, PM_IRQ = 3'd6
  } pin_mode_e;

  function automatic logic [7:0] cfg_base(int r);
    case (r)
      CFG_INT:  return 8'h10;
      CFG_MSK:  return 8'h20;
      CFG_PAT1: return 8'h30;
      CFG_PAT0: return 8'h40;
      default:  return 8'h70;
    endcase
  endfunction

  function automatic logic [31:0] cfg_rst(int r);
    return (r == CFG_PAT1 || r == CFG_PAT0) ? '1 : '0;
  endfunction
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/pfc_port_bank.sv
module pfc_port_bank
  import pfc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  ofs_i,
  input  logic [31:0] wdata_i,
  output logic [NUM_CFG-1:0][31:0] cfg_o
);
  for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
    logic        set_hit, clr_hit;
    logic [31:0] val_q;
    assign set_hit = wr_i && (ofs_i == (cfg_base(r) | OFS_SET));
    assign clr_hit = wr_i && (ofs_i == (cfg_base(r) | OFS_CLR));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      val_q <= cfg_rst(r);
      else if (set_hit) val_q <= val_q | wdata_i;
      else if (clr_hit) val_q <= val_q & ~wdata_i;
    end
    assign cfg_o[r] = val_q;
  end
endmodule

// File: rtl/pfc_pin_dec.sv
module pfc_pin_dec
  import pfc_pkg::*;
(
  input  logic       irq_i,
  input  logic       msk_i,
  input  logic       pat1_i,
  input  logic       pat0_i,
  input  logic       pdis_i,
  input  logic       up_cap_i,
  input  logic       dn_cap_i,
  output logic [2:0] mode_o,
  output logic       oe_o,
  output logic       out_o,
  output logic       pu_o,
  output logic       pd_o
);
  pin_mode_e mode;
  always_comb begin
    if (irq_i)      mode = PM_IRQ;
    else if (msk_i) mode = pat1_i ? PM_GPI : PM_GPO;
    else            mode = pin_mode_e'({1'b0, pat1_i, pat0_i});
  end
  assign mode_o = mode;
  assign oe_o   = (mode == PM_GPO);
  assign out_o  = oe_o & pat0_i;
  assign pu_o   = ~pdis_i & up_cap_i;
  assign pd_o   = ~pdis_i & dn_cap_i;
endmodule

// File: rtl/pinfunc_ctrl.sv
module pinfunc_ctrl
  import pfc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12,
  parameter logic [NUM_PORTS*32-1:0] PULLUP_CAP =
    128'h0000FFFF_FFFFFFFF_FFF0030C_FFFFFFFF,
  parameter logic [NUM_PORTS*32-1:0] PULLDN_CAP =
    128'hFFFF0000_00000000_000F0C03_00000000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_en_i,
  input  logic                      bus_we_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [31:0]               bus_wdata_i,
  output logic [31:0]               bus_rdata_o,
  input  logic [NUM_PORTS*32-1:0]   pad_in_i,
  output logic [NUM_PORTS*96-1:0]   pin_mode_o,
  output logic [NUM_PORTS*32-1:0]   pad_out_o,
  output logic [NUM_PORTS*32-1:0]   pad_oe_o,
  output logic [NUM_PORTS*32-1:0]   pull_up_o,
  output logic [NUM_PORTS*32-1:0]   pull_dn_o
);
  localparam int PIN_CNT = NUM_PORTS * PORT_PINS;
  localparam int PORT_W  = ADDR_W - 8;

  logic [PORT_W-1:0] port_sel;
  logic [7:0]        ofs;
  logic              port_ok;
  logic [NUM_CFG-1:0][31:0] cfg [NUM_PORTS];
  logic [PIN_CNT-1:0] pad_sync;
  logic [31:0]        rd_val;

  assign port_sel = bus_addr_i[ADDR_W-1:8];
  assign ofs      = bus_addr_i[7:0];
  assign port_ok  = 32'(port_sel) < NUM_PORTS;

  pfc_sync #(.W(PIN_CNT)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_in_i), .q_o(pad_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr;
    assign wr = bus_en_i && bus_we_i && port_ok && (port_sel == PORT_W'(p));
    pfc_port_bank u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .ofs_i(ofs),
      .wdata_i(bus_wdata_i), .cfg_o(cfg[p])
    );
  end

  for (genvar n = 0; n < PIN_CNT; n++) begin : g_pin
    localparam int P = n / PORT_PINS;
    localparam int B = n % PORT_PINS;
    pfc_pin_dec u_dec (
      .irq_i   (cfg[P][CFG_INT][B]),
      .msk_i   (cfg[P][CFG_MSK][B]),
      .pat1_i  (cfg[P][CFG_PAT1][B]),
      .pat0_i  (cfg[P][CFG_PAT0][B]),
      .pdis_i  (cfg[P][CFG_PDIS][B]),
      .up_cap_i(PULLUP_CAP[n]),
      .dn_cap_i(PULLDN_CAP[n]),
      .mode_o  (pin_mode_o[3*n +: 3]),
      .oe_o    (pad_oe_o[n]),
      .out_o   (pad_out_o[n]),
      .pu_o    (pull_up_o[n]),
      .pd_o    (pull_dn_o[n])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_ok && port_sel == PORT_W'(p)) begin
        for (int r = 0; r < NUM_CFG; r++)
          if (ofs == cfg_base(r)) rd_val = cfg[p][r];
        if (ofs == OFS_FLAG) rd_val = pad_sync[p*PORT_PINS +: PORT_PINS];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     bus_rdata_o <= '0;
    else if (bus_en_i && !bus_we_i)  bus_rdata_o <= rd_val;
  end
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12,
  parameter logic [NUM_PORTS*32-1:0] PULLUP_CAP = '0,
  parameter logic [NUM_PORTS*32-1:0] PULLDN_CAP = '0
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    bus_en_i,
  input logic                    bus_we_i,
  input logic [ADDR_W-1:0]       bus_addr_i,
  input logic [31:0]             bus_wdata_i,
  input logic [31:0]             bus_rdata_o,
  input logic [NUM_PORTS*96-1:0] pin_mode_o,
  input logic [NUM_PORTS*32-1:0] pad_out_o,
  input logic [NUM_PORTS*32-1:0] pull_up_o,
  input logic [NUM_PORTS*32-1:0] pull_dn_o
);
  logic bad_port, alias_rd, wr0;
  assign bad_port = 32'(bus_addr_i[ADDR_W-1:8]) >= NUM_PORTS;
  assign alias_rd = bus_en_i && !bus_we_i && (bus_addr_i[3:0] != 4'h0);
  assign wr0      = bus_en_i && bus_we_i && (bus_wdata_i == '0);

  p_oob_write_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_we_i && bad_port) |=>
      ($stable(pin_mode_o) && $stable(pull_up_o) && $stable(pull_dn_o) && $stable(pad_out_o)));

  p_alias_reads_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_rd |=> (bus_rdata_o == '0));

  p_pull_within_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pull_up_o & ~PULLUP_CAP) == '0) && ((pull_dn_o & ~PULLDN_CAP) == '0));

  p_mask_gives_gpio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_we_i && bus_addr_i == ADDR_W'(12'h024) && bus_wdata_i[0]) |=>
      pin_mode_o[2]);

  p_zero_data_no_change_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 |=> ($stable(pin_mode_o) && $stable(pull_up_o) && $stable(pad_out_o)));
endmodule

bind pinfunc_ctrl pfc_checker #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W),
  .PULLUP_CAP(PULLUP_CAP), .PULLDN_CAP(PULLDN_CAP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .pin_mode_o(pin_mode_o), .pad_out_o(pad_out_o),
  .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o)
);

// File: tb/pinfunc_ctrl_test.sv
module pinfunc_ctrl_test;
  localparam int NP = 4;
  localparam int PC = NP * 32;
  localparam logic [PC-1:0] UP_CAP = 128'h0000FFFF_FFFFFFFF_FFF0030C_FFFFFFFF;
  localparam logic [PC-1:0] DN_CAP = 128'hFFFF0000_00000000_000F0C03_00000000;

  logic clk = 0, rst_n = 0;
  logic en = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [PC-1:0] pad_in = '0;
  logic [NP*96-1:0] mode;
  logic [PC-1:0] pout, poe, pup, pdn;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_pend = 0;

  always #10 clk = ~clk;

  pinfunc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_in_i(pad_in), .pin_mode_o(mode),
    .pad_out_o(pout), .pad_oe_o(poe), .pull_up_o(pup), .pull_dn_o(pdn)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); en = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); en = 0; we = 0;
  endtask

  task automatic bus_rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); en = 1; we = 0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); en = 0;
  endtask

  function automatic logic [31:0] pm(int n);
    return 32'(mode[3*n +: 3]);
  endfunction

  // monitor
  always @(posedge clk) rd_pend <= en & ~we;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R1 unexpected read act=%h exp=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #4_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [PC*3-1:0] snap_mode;
    logic [PC-1:0] snap_up;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    check("R2 mode pin0", pm(0), 32'd3);
    check("R2 mode pin127", pm(127), 32'd3);
    check("R2 pull_up", pup[31:0], UP_CAP[31:0]);
    bus_rd(12'h010, 32'h0, "R2 int");
    bus_rd(12'h130, 32'hFFFFFFFF, "R2 pat1");
    bus_rd(12'h370, 32'h0, "R2 pdis");
    // R6 GPIO in/out on pin 37
    bus_wr(12'h124, 32'h20);
    check("R6 gpio in", pm(37), 32'd4);
    check("R6 oe in", 32'(poe[37]), 32'd0);
    bus_wr(12'h138, 32'h20);
    check("R6 gpio out", pm(37), 32'd5);
    check("R6 oe out", 32'(poe[37]), 32'd1);
    check("R6 out=pat0 1", 32'(pout[37]), 32'd1);
    bus_wr(12'h148, 32'h20);
    check("R6 out=pat0 0", 32'(pout[37]), 32'd0);
    bus_rd(12'h140, 32'hFFFFFFDF, "R4 pat0 clear");
    bus_rd(12'h120, 32'h20, "R1 msk read");
    // R5 function decode on pin 71
    bus_wr(12'h238, 32'h80);
    check("R5 fn1", pm(71), 32'd1);
    bus_wr(12'h248, 32'h80);
    check("R5 fn0", pm(71), 32'd0);
    bus_wr(12'h234, 32'h80);
    check("R5 fn2", pm(71), 32'd2);
    check("R5 pin70 untouched", pm(70), 32'd3);
    bus_rd(12'h240, 32'hFFFFFF7F, "R4 pat0 port2");
    // R3 set preserves other bits
    bus_wr(12'h014, 32'h0000_0300);
    bus_wr(12'h014, 32'h0000_0001);
    bus_rd(12'h010, 32'h0000_0301, "R3 set keeps bits");
    bus_wr(12'h018, 32'h0000_0100);
    bus_rd(12'h010, 32'h0000_0201, "R4 clear keeps bits");
    bus_wr(12'h018, 32'h0000_0201);
    // R7 interrupt mode
    bus_wr(12'h314, 32'h1);
    check("R7 irq mode", pm(96), 32'd6);
    check("R7 no drive", 32'(poe[96]), 32'd0);
    // R8 pulls
    check("R8 pin32 up", 32'(pup[32]), 32'(UP_CAP[32]));
    check("R8 pin32 dn", 32'(pdn[32]), 32'(DN_CAP[32]));
    check("R8 pin34 up on", 32'(pup[34]), 32'd1);
    bus_wr(12'h174, 32'h4);
    check("R8 pin34 up off", 32'(pup[34]), 32'd0);
    check("R8 pin35 up kept", 32'(pup[35]), 32'(UP_CAP[35]));
    // R9 flag sync
    @(negedge clk); pad_in[37] = 1'b1; pad_in[64] = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(12'h150, 32'h20, "R9 flag port1");
    bus_rd(12'h250, 32'h1, "R9 flag port2");
    // R10 aliases / unmapped
    bus_rd(12'h234, 32'h0, "R10 set alias read");
    bus_rd(12'h248, 32'h0, "R10 clr alias read");
    snap_mode = mode; snap_up = pup;
    bus_wr(12'h064, 32'hFFFFFFFF);
    bus_wr(12'h058, 32'hFFFFFFFF);
    check("R10 unmapped write mode", 32'(mode == snap_mode), 32'd1);
    bus_rd(12'h060, 32'h0, "R10 unmapped read");
    // R11 out-of-range port
    bus_wr(12'h438, 32'hFFFFFFFF);
    bus_wr(12'h524, 32'hFFFFFFFF);
    check("R11 oob mode", 32'(mode == snap_mode), 32'd1);
    check("R11 oob pull", 32'(pup == snap_up), 32'd1);
    bus_rd(12'h430, 32'h0, "R11 oob read");
    bus_rd(12'h030, 32'hFFFFFFFF, "R11 port0 pat1 intact");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R1 reads pending act=%0d exp=0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule